// File: doc/BRIEF.md
# Vectored Priority Chain Interrupt Node

This block is the interrupt front end of one peripheral that sits in a serial priority chain. Priority is set purely by position: an enable input arrives from the device closer to the head of the chain, and an enable output is passed to the next device further down. The head of the chain has its enable input tied high. When the peripheral raises a request, the node records it as pending. It pulls the shared active-low interrupt line for as long as it is allowed to by its enable input, and it blocks every device below it.

When the processor acknowledges, it runs an opcode-fetch cycle in which the I/O strobe replaces the memory strobe. The one node that sees its enable input high and its own enable output low puts its programmed 8-bit vector on the data bus. The processor uses that vector as the low byte of an indirect call table address. At the same moment the request moves from pending to in service. The node keeps the chain below it blocked until it sees the two-byte return-from-interrupt opcode in the instruction stream while its enable input is high. No software end-of-interrupt access exists: the node decodes that return sequence itself from the opcode fetches.

All bus strobes are sampled on the block clock. A fetch or an acknowledge is taken once, on the first clock in which its strobe pattern appears.

Top module: `chain_irq_node`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, int_n is 1, data_oe is 0 and ieo equals iei.
- R2: A src_req pulse makes a request pending. int_n is 0 exactly while a request is pending and iei is 1.
- R3: ieo is 0 whenever iei is 0. With nothing pending and nothing in service, ieo equals iei.
- R4: A pending request pulls ieo low only once it has been registered while m1_n is 1. A request arriving while m1_n is 0 leaves ieo unchanged until m1_n returns to 1, even if m1_n stays 0 for several clocks.
- R5: An acknowledge cycle is m1_n=0, iorq_n=0, mreq_n=1. In it, with iei=1 and ieo=0, data_oe is 1 and data_out equals vec_cfg. data_out is 0 whenever data_oe is 0.
- R6: An acknowledge that finds a pending request with iei=1 clears the pending flag and sets in-service in the same clock. int_n then returns to 1, and ieo stays 0 after m1_n returns to 1.
- R7: An acknowledge with iei=0, or with nothing pending or in service, drives no vector and leaves any pending request in place.
- R8: A fetch cycle is m1_n=0, mreq_n=0, and its opcode is sampled on its first clock. Two consecutive fetch cycles carrying 8'hED and then 8'h4D, with iei=1 on the second, end in-service, and ieo again follows iei. Clocks without a fetch may lie between the two fetches.
- R9: A fetch carrying any other opcode between 8'hED and 8'h4D, or an 8'h4D without the preceding 8'hED, leaves in-service unchanged.
- R10: A return sequence completed while iei=0 is ignored. The node stays in service, and ieo stays 0 once iei returns to 1.
- R11: A repeated prefix (8'hED, 8'hED, 8'h4D) still ends in-service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iei | input | 1 | Chain enable from the higher-priority neighbour |
| ieo | output | 1 | Chain enable toward the lower-priority neighbour |
| src_req | input | 1 | Request pulse from the peripheral's own logic |
| m1_n | input | 1 | Active-low opcode-fetch cycle marker |
| mreq_n | input | 1 | Active-low memory request strobe |
| iorq_n | input | 1 | Active-low I/O request strobe |
| data_in | input | DATA_W | Data bus as seen during fetches |
| vec_cfg | input | DATA_W | Programmed interrupt vector |
| data_out | output | DATA_W | Vector driven toward the data bus, 0 when idle |
| data_oe | output | 1 | Data bus drive enable for data_out |
| int_n | output | 1 | Active-low interrupt request, intended for a wired-low line |

## Verification
The bench builds the node with its defaults: an 8-bit bus, a return prefix of 8'hED and a second byte of 8'h4D. vec_cfg is held at 8'hA6, so a vector on the bus is easy to tell apart from the all-zero idle value. With real opcode values the bench can walk the prefix-reset paths: a foreign fetch between the two bytes, a lone second byte, a doubled prefix, and a return seen while the chain above is blocked. A held fetch strobe checks that an opcode is sampled only once. Requests are raised both inside and outside M1, which covers both halves of the ieo gating rule.

// File: rtl/chain_irq_pkg.sv
package chain_irq_pkg;

  // Return-from-interrupt byte pair seen on consecutive opcode fetches
  localparam logic [7:0] RET_PREFIX_DEF = 8'hED;
  localparam logic [7:0] RET_OPCODE_DEF = 8'h4D;

  // Decoded bus activity for one clock
  typedef struct packed {
    logic fetch_act;  // opcode fetch strobes active
    logic ack_act;    // acknowledge strobes active
    logic fetch_evt;  // first clock of a fetch
    logic ack_evt;    // first clock of an acknowledge
  } bus_evt_t;

endpackage

// File: rtl/chain_bus_monitor.sv
module chain_bus_monitor
  import chain_irq_pkg::*;
(
  input  logic     clk,
  input  logic     srst_n,
  input  logic     m1_n,
  input  logic     mreq_n,
  input  logic     iorq_n,
  output bus_evt_t evt
);

  logic fetch_now, ack_now;
  logic fetch_q, ack_q;
  logic fetch_d, ack_d;

  // Strobe pattern decode
  always_comb begin
    fetch_now = ~m1_n & ~mreq_n;
    ack_now   = ~m1_n & ~iorq_n & mreq_n;
  end

  // Next state: remember the previous strobe pattern
  always_comb begin
    fetch_d = fetch_now;
    ack_d   = ack_now;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fetch_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      fetch_q <= fetch_d;
      ack_q   <= ack_d;
    end
  end

  always_comb begin
    evt.fetch_act = fetch_now;
    evt.ack_act   = ack_now;
    evt.fetch_evt = fetch_now & ~fetch_q;
    evt.ack_evt   = ack_now & ~ack_q;
  end

endmodule

// File: rtl/chain_ret_decoder.sv
module chain_ret_decoder #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] RET_PREFIX = DATA_W'(8'hED),
  parameter logic [DATA_W-1:0] RET_OPCODE = DATA_W'(8'h4D)
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              fetch_evt,
  input  logic [DATA_W-1:0] opcode,
  output logic              ret_hit
);

  logic prefix_q, prefix_d;
  logic is_prefix, is_second;

  always_comb begin
    is_prefix = (opcode == RET_PREFIX);
    is_second = (opcode == RET_OPCODE);
  end

  // Any fetch rewrites the prefix flag; non-fetch clocks keep it
  always_comb begin
    prefix_d = prefix_q;
    if (fetch_evt) begin
      prefix_d = is_prefix;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prefix_q <= 1'b0;
    end else begin
      prefix_q <= prefix_d;
    end
  end

  always_comb begin
    ret_hit = fetch_evt & prefix_q & is_second;
  end

endmodule

// File: rtl/chain_irq_state.sv
module chain_irq_state (
  input  logic clk,
  input  logic srst_n,
  input  logic iei,
  input  logic src_req,
  input  logic m1_n,
  input  logic ack_evt,
  input  logic ret_hit,
  output logic pending,
  output logic in_service,
  output logic chain_block
);

  logic pend_q, pend_d;
  logic serv_q, serv_d;
  logic gate_q, gate_d;
  logic accept, release_ok;

  always_comb begin
    accept     = ack_evt & iei & pend_q;
    release_ok = ret_hit & iei;
  end

  // Next state
  always_comb begin
    pend_d = src_req | (pend_q & ~accept);
    serv_d = accept  | (serv_q & ~release_ok);
    // pending view for the chain is frozen while M1 is low
    gate_d = gate_q;
    if (m1_n) begin
      gate_d = pend_d;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      serv_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      serv_q <= serv_d;
      gate_q <= gate_d;
    end
  end

  always_comb begin
    pending     = pend_q;
    in_service  = serv_q;
    chain_block = serv_q | gate_q;
  end

endmodule

// File: rtl/chain_irq_node.sv
module chain_irq_node
  import chain_irq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] RET_PREFIX = DATA_W'(RET_PREFIX_DEF),
  parameter logic [DATA_W-1:0] RET_OPCODE = DATA_W'(RET_OPCODE_DEF),
  parameter int                SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iei,
  output logic              ieo,
  input  logic              src_req,
  input  logic              m1_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] vec_cfg,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              int_n
);

  localparam int SYNC_MSB = SYNC_DEPTH - 1;

  logic [SYNC_MSB:0] rsync_q;
  logic              srst_n;
  bus_evt_t          evt;
  logic              ret_hit;
  logic              pending;
  logic              in_service;
  logic              chain_block;

  // Reset asserts at once, releases after SYNC_DEPTH clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_MSB-1:0], 1'b1};
    end
  end

  always_comb srst_n = rsync_q[SYNC_MSB];

  chain_bus_monitor u_bus (
    .clk    (clk),
    .srst_n (srst_n),
    .m1_n   (m1_n),
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .evt    (evt)
  );

  chain_ret_decoder #(
    .DATA_W     (DATA_W),
    .RET_PREFIX (RET_PREFIX),
    .RET_OPCODE (RET_OPCODE)
  ) u_ret (
    .clk       (clk),
    .srst_n    (srst_n),
    .fetch_evt (evt.fetch_evt),
    .opcode    (data_in),
    .ret_hit   (ret_hit)
  );

  chain_irq_state u_state (
    .clk         (clk),
    .srst_n      (srst_n),
    .iei         (iei),
    .src_req     (src_req),
    .m1_n        (m1_n),
    .ack_evt     (evt.ack_evt),
    .ret_hit     (ret_hit),
    .pending     (pending),
    .in_service  (in_service),
    .chain_block (chain_block)
  );

  // Chain and bus outputs
  always_comb begin
    ieo      = iei & ~chain_block;
    int_n    = ~(pending & iei);
    data_oe  = evt.ack_act & iei & ~ieo;
    data_out = data_oe ? vec_cfg : '0;
  end

endmodule

// File: rtl/chain_irq_node_chk.sv
module chain_irq_node_chk
  import chain_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              iei,
  input logic              ieo,
  input logic              int_n,
  input logic              m1_n,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic [DATA_W-1:0] vec_cfg,
  input bus_evt_t          evt,
  input logic              pending,
  input logic              in_service,
  input logic              ret_hit
);

  a_r2_irq_needs_iei: assert property (@(posedge clk) disable iff (!srst_n)
    !int_n |-> (iei && pending));

  a_r3_ieo_blocked: assert property (@(posedge clk) disable iff (!srst_n)
    !iei |-> !ieo);

  a_r5_vector_on_bus: assert property (@(posedge clk) disable iff (!srst_n)
    data_oe |-> (data_out == vec_cfg));

  a_r7_drive_only_in_ack: assert property (@(posedge clk) disable iff (!srst_n)
    data_oe |-> (!m1_n && !iorq_n && mreq_n && iei));

  a_r6_ack_to_service: assert property (@(posedge clk) disable iff (!srst_n)
    (evt.ack_evt && iei && pending) |=> (in_service && !ieo));

  a_r8_return_ends_service: assert property (@(posedge clk) disable iff (!srst_n)
    (ret_hit && iei) |=> !in_service);

  a_r10_service_held: assert property (@(posedge clk) disable iff (!srst_n)
    (in_service && !iei) |=> in_service);

endmodule

bind chain_irq_node chain_irq_node_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .iei        (iei),
  .ieo        (ieo),
  .int_n      (int_n),
  .m1_n       (m1_n),
  .mreq_n     (mreq_n),
  .iorq_n     (iorq_n),
  .data_oe    (data_oe),
  .data_out   (data_out),
  .vec_cfg    (vec_cfg),
  .evt        (evt),
  .pending    (pending),
  .in_service (in_service),
  .ret_hit    (ret_hit)
);

// File: tb/chain_irq_node_test.sv
module chain_irq_node_test;

  localparam int NV = 37;
  localparam logic [7:0] VEC = 8'hA6;

  // {iei, src_req, m1_n, mreq_n, iorq_n, data_in} , {int_n, ieo, data_oe, data_out}
  // bus: idle 111, fetch 001, acknowledge 010
  localparam logic [23:0] TAB [NV] = '{
    {5'b10111, 8'h00, 3'b110, 8'h00},  // 0  R1 idle after reset
    {5'b00111, 8'h00, 3'b100, 8'h00},  // 1  R3 iei low
    {5'b11111, 8'h00, 3'b000, 8'h00},  // 2  R2 request
    {5'b00111, 8'h00, 3'b100, 8'h00},  // 3  R2 iei low hides request
    {5'b10111, 8'h00, 3'b000, 8'h00},  // 4  R2
    {5'b10010, 8'h00, 3'b101, VEC  },  // 5  R5 acknowledge
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 6  R6 in service
    {5'b10001, 8'hED, 3'b100, 8'h00},  // 7  R8 prefix
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 8  R8
    {5'b10001, 8'h4D, 3'b110, 8'h00},  // 9  R8 second byte
    {5'b10111, 8'h00, 3'b110, 8'h00},  // 10 R8
    {5'b11001, 8'h00, 3'b010, 8'h00},  // 11 R4 request inside M1
    {5'b10001, 8'h00, 3'b010, 8'h00},  // 12 R4 M1 held
    {5'b10111, 8'h00, 3'b000, 8'h00},  // 13 R4 M1 ends
    {5'b00010, 8'h00, 3'b100, 8'h00},  // 14 R7 ack with iei low
    {5'b00111, 8'h00, 3'b100, 8'h00},  // 15 R7
    {5'b10111, 8'h00, 3'b000, 8'h00},  // 16 R7 still pending
    {5'b10010, 8'h00, 3'b101, VEC  },  // 17 R5 acknowledge
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 18 R5
    {5'b00001, 8'hED, 3'b100, 8'h00},  // 19 R10
    {5'b00111, 8'h00, 3'b100, 8'h00},  // 20 R10
    {5'b00001, 8'h4D, 3'b100, 8'h00},  // 21 R10 return with iei low
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 22 R10 still in service
    {5'b10001, 8'hED, 3'b100, 8'h00},  // 23 R9
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 24 R9
    {5'b10001, 8'h00, 3'b100, 8'h00},  // 25 R9 foreign opcode
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 26 R9
    {5'b10001, 8'h4D, 3'b100, 8'h00},  // 27 R9 no effect
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 28 R9
    {5'b10001, 8'hED, 3'b100, 8'h00},  // 29 R11
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 30 R11
    {5'b10001, 8'hED, 3'b100, 8'h00},  // 31 R11 repeated prefix
    {5'b10111, 8'h00, 3'b100, 8'h00},  // 32 R11
    {5'b10001, 8'h4D, 3'b110, 8'h00},  // 33 R11 service ends
    {5'b10111, 8'h00, 3'b110, 8'h00},  // 34 R11
    {5'b10010, 8'h00, 3'b110, 8'h00},  // 35 R7 ack with nothing pending
    {5'b10111, 8'h00, 3'b110, 8'h00}   // 36 R7
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iei, src_req, m1_n, mreq_n, iorq_n;
  logic [7:0] data_in;
  logic [7:0] vec_cfg;
  logic       ieo, data_oe, int_n;
  logic [7:0] data_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  chain_irq_node uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .iei      (iei),
    .ieo      (ieo),
    .src_req  (src_req),
    .m1_n     (m1_n),
    .mreq_n   (mreq_n),
    .iorq_n   (iorq_n),
    .data_in  (data_in),
    .vec_cfg  (vec_cfg),
    .data_out (data_out),
    .data_oe  (data_oe),
    .int_n    (int_n)
  );

  function automatic string row_req(int i);
    if (i == 0)       return "R1";
    else if (i == 1)  return "R3";
    else if (i <= 4)  return "R2";
    else if (i == 5)  return "R5";
    else if (i == 6)  return "R6";
    else if (i <= 10) return "R8";
    else if (i <= 13) return "R4";
    else if (i <= 16) return "R7";
    else if (i <= 18) return "R5";
    else if (i <= 22) return "R10";
    else if (i <= 28) return "R9";
    else if (i <= 34) return "R11";
    else              return "R7";
  endfunction

  task automatic check(string req, logic [10:0] exp);
    logic [10:0] got;
    got = {int_n, ieo, data_oe, data_out};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got int_n/ieo/oe/data=%b/%b/%b/%h expected %b/%b/%b/%h",
               req, got[10], got[9], got[8], got[7:0],
               exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic drive(logic [12:0] s);
    {iei, src_req, m1_n, mreq_n, iorq_n, data_in} = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang expected end");
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    vec_cfg = VEC;
    drive({5'b10111, 8'h00});
    repeat (3) @(negedge clk);
    check("R1", {3'b110, 8'h00});  // held in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {3'b110, 8'h00});  // released, idle

    for (int i = 0; i < NV; i++) begin
      drive(TAB[i][23:11]);
      @(negedge clk);
      check(row_req(i), TAB[i][10:0]);
    end

    // R1: reset in the middle of a pending request
    drive({5'b11111, 8'h00});
    @(negedge clk);
    drive({5'b10111, 8'h00});
    check("R2", {3'b000, 8'h00});
    #1 rst_n = 1'b0;
    #1 check("R1", {3'b110, 8'h00});
    iei = 1'b0;
    #1 check("R1", {3'b100, 8'h00});
    @(negedge clk);
    iei   = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {3'b110, 8'h00});  // pending cleared by reset

    // R7: acknowledge right after reset with nothing pending
    drive({5'b10010, 8'h00});
    @(negedge clk);
    check("R7", {3'b110, 8'h00});
    drive({5'b10111, 8'h00});
    @(negedge clk);
    check("R3", {3'b110, 8'h00});

    finish_run();
  end

endmodule